// File: doc/BRIEF.md
# Fabric Traffic Counter with Port Filter

This block counts read and write transactions on a host fabric with four traffic sources: two serial expansion links, a coherent processor link and the memory-mapped I/O path. Each source has a read and a write event. Decoding logic outside the block raises a one-cycle strobe per transaction on that event's input and tags it with a 2-bit port number. Eight accumulators, one per event, run at the same time. Software chooses which one it sees through a single counter register, and that register also returns the chosen event code in its top nibble.

The counter runs in one of two modes. In overall mode every strobe is counted whatever its tag. In port mode only strobes whose tag equals a programmed port ID are counted. Software can also freeze all accumulators or clear them. A free-running cycle counter sits beside the accumulators, and software cannot clear or freeze it.

The registers are 64 bits wide and are read as two 32-bit halves. Reading a low half captures the matching high half, so a split read stays consistent. A parameter builds a reduced variant that omits the second-link and processor-link events.

Top module: `ftc_fabric_counter`

## Requirements
- R1: The control word at byte offset 0x20 holds freeze in bit 8, the event selector in bits 19:16, the port ID in bits 21:20 and the filter enable in bit 23. A read of 0x20 returns these fields with every other bit zero, and bit 0 always reads as 0. A read of 0x24 returns zero.
- R2: A control write with bit 0 set clears all eight accumulators at that write's clock edge. The clear wins over any strobe arriving in the same cycle.
- R3: Event codes are 0/1 first-link read/write, 2/3 second-link read/write, 4/5 processor-link read/write and 6/7 I/O read/write. A strobe on event input i adds exactly 1 to accumulator i at that edge. Strobes on different events in the same cycle are all counted.
- R4: With the filter bit at 0, strobes with any tag are counted. With the filter bit at 1, only strobes whose tag equals the port ID are counted. Changing the filter or the port ID does not clear the accumulators.
- R5: While freeze is 1, no accumulator changes. Counting resumes after freeze is written back to 0.
- R6: The counter register at 0x28 (low) and 0x2C (high) holds the echoed event code in bits 63:60 and the count of that event in bits 59:0. The echo takes a new selector one cycle after the control register does, so reads issued at the second edge after the write's edge, or later, show it. Selector codes 8 to 15 read a count of zero.
- R7: The cycle counter at 0x30 (low) and 0x34 (high) increases by one on every clock after reset. It ignores the clear and freeze bits.
- R8: With REDUCED set, strobes on events 2, 3, 4 and 5 are ignored and those events always read a count of zero.
- R9: A read of 0x28 or 0x30 captures the upper 32 bits of that register at the read edge. A later read of 0x2C or 0x34 returns the captured value, even if the register has changed since.
- R10: A read request gives rd_valid high with rd_data on the next cycle, and rd_valid is low in every other cycle. Unmapped offsets read zero. After reset, all registers read zero except the cycle counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the 32-bit word |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 32 | Read data |
| ev_stb | input | 8 | One strobe per event code |
| ev_port | input | 16 | 2-bit port tag per event, event i in bits 2i+1:2i |

## Verification
A table of eight cases pairs each event code with a filter setting and a strobe tag. Each case also strobes a neighbouring event in the same cycles. This separates correct routing of a strobe to its own accumulator, the effect of a matching versus a non-matching tag in port mode, and the effect of tags in overall mode. Directed sequences follow. They exercise freeze and unfreeze, and a mode change without a clear. They also cover a clear that collides with a strobe and the one-cycle lag of the echo. The rest cover the capture of the high half between the two halves of a split read, an out-of-range selector, and a reduced-variant instance driven by the same strobes as the full one.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
    localparam int NUM_EVT = 8;
    localparam int EVT_W   = 4;
    localparam int PORT_W  = 2;
    localparam int CYC_W   = 64;

    typedef enum logic [EVT_W-1:0] {
        EV_L0_RD = 4'd0, EV_L0_WR = 4'd1,
        EV_L1_RD = 4'd2, EV_L1_WR = 4'd3,
        EV_CL_RD = 4'd4, EV_CL_WR = 4'd5,
        EV_IO_RD = 4'd6, EV_IO_WR = 4'd7
    } ev_code_e;

    localparam logic [7:0] OFS_CTRL = 8'h20;
    localparam logic [7:0] OFS_CNT  = 8'h28;
    localparam logic [7:0] OFS_CYC  = 8'h30;

    localparam int B_CLR     = 0;
    localparam int B_FRZ     = 8;
    localparam int B_EVS_LO  = 16;
    localparam int B_PORT_LO = 20;
    localparam int B_FILT    = 23;

    typedef struct packed {
        logic              freeze;
        logic [EVT_W-1:0]  evsel;
        logic [PORT_W-1:0] port;
        logic              filt;
    } ctrl_t;

    function automatic logic [NUM_EVT-1:0] supp_mask(input bit reduced);
        logic [NUM_EVT-1:0] m;
        for (int i = 0; i < NUM_EVT; i++) begin
            m[i] = !(reduced && (i == int'(EV_L1_RD) || i == int'(EV_L1_WR) ||
                                 i == int'(EV_CL_RD) || i == int'(EV_CL_WR)));
        end
        return m;
    endfunction
endpackage

// File: rtl/ftc_ctrl_regs.sv
module ftc_ctrl_regs
    import ftc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  ctrl_t            wr_val,
    input  logic             wr_clr,
    output ctrl_t            ctrl_o,
    output logic [EVT_W-1:0] echo_o,
    output logic             clr_o
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [EVT_W-1:0] echo;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // echo trails the selector by one register stage
        st_d.echo = st_q.ctrl.evsel;
        if (wr_en) begin
            st_d.ctrl = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign echo_o = st_q.echo;
    assign clr_o  = wr_en && wr_clr;
endmodule

// File: rtl/ftc_event_bank.sv
module ftc_event_bank
    import ftc_pkg::*;
#(
    parameter bit REDUCED = 1'b0,
    parameter int CNT_W   = 60
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_EVT-1:0]        stb,
    input  logic [NUM_EVT*PORT_W-1:0] tags,
    input  logic                      clr,
    input  logic                      freeze,
    input  logic                      filt,
    input  logic [PORT_W-1:0]         port_sel,
    input  logic [EVT_W-1:0]          rd_sel,
    output logic [CNT_W-1:0]          sel_count
);
    localparam logic [NUM_EVT-1:0] SUPP = supp_mask(REDUCED);

    typedef struct packed {
        logic [NUM_EVT-1:0][CNT_W-1:0] acc;
    } st_t;

    st_t st_d, st_q;
    logic [NUM_EVT-1:0] hit;

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_ev
        if (SUPP[g]) begin : g_live
            assign hit[g] = stb[g] &&
                            (!filt || tags[g*PORT_W +: PORT_W] == port_sel);
        end else begin : g_absent
            assign hit[g] = 1'b0;
        end
    end

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.acc = '0;
        end else if (!freeze) begin
            for (int i = 0; i < NUM_EVT; i++) begin
                if (hit[i]) st_d.acc[i] = st_q.acc[i] + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        sel_count = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (rd_sel == EVT_W'(i)) sel_count = st_q.acc[i];
        end
    end
endmodule

// File: rtl/ftc_read_port.sv
module ftc_read_port
    import ftc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 60
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  ctrl_t             ctrl,
    input  logic [EVT_W-1:0]  echo,
    input  logic [CNT_W-1:0]  sel_count,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic [CYC_W-1:0]  cyc
);
    localparam logic [ADDR_W-1:0] A_CTRL_LO = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CTRL_HI = ADDR_W'(OFS_CTRL + 8'd4);
    localparam logic [ADDR_W-1:0] A_CNT_LO  = ADDR_W'(OFS_CNT);
    localparam logic [ADDR_W-1:0] A_CNT_HI  = ADDR_W'(OFS_CNT + 8'd4);
    localparam logic [ADDR_W-1:0] A_CYC_LO  = ADDR_W'(OFS_CYC);
    localparam logic [ADDR_W-1:0] A_CYC_HI  = ADDR_W'(OFS_CYC + 8'd4);

    typedef struct packed {
        logic             vld;
        logic [31:0]      data;
        logic [31:0]      hi_hold;
        logic [CYC_W-1:0] cyc;
    } st_t;

    st_t st_d, st_q;
    logic [63:0] cnt_word;
    logic [31:0] ctrl_word;

    always_comb begin
        cnt_word                    = '0;
        cnt_word[CNT_W-1:0]         = sel_count;
        cnt_word[63:64-EVT_W]       = echo;
        ctrl_word                   = '0;
        ctrl_word[B_FRZ]            = ctrl.freeze;
        ctrl_word[B_EVS_LO +: EVT_W] = ctrl.evsel;
        ctrl_word[B_PORT_LO +: PORT_W] = ctrl.port;
        ctrl_word[B_FILT]           = ctrl.filt;
    end

    always_comb begin
        st_d      = st_q;
        st_d.cyc  = st_q.cyc + CYC_W'(1);
        st_d.vld  = rd_en;
        st_d.data = '0;
        if (rd_en) begin
            case (addr)
                A_CTRL_LO: st_d.data = ctrl_word;
                A_CTRL_HI: st_d.data = '0;
                A_CNT_LO: begin
                    st_d.data    = cnt_word[31:0];
                    st_d.hi_hold = cnt_word[63:32];
                end
                A_CYC_LO: begin
                    st_d.data    = st_q.cyc[31:0];
                    st_d.hi_hold = st_q.cyc[63:32];
                end
                A_CNT_HI, A_CYC_HI: st_d.data = st_q.hi_hold;
                default: st_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = st_q.vld;
    assign rd_data  = st_q.data;
    assign cyc      = st_q.cyc;
endmodule

// File: rtl/ftc_fabric_counter.sv
module ftc_fabric_counter
    import ftc_pkg::*;
#(
    parameter bit REDUCED = 1'b0,
    parameter int CNT_W   = 60,
    parameter int ADDR_W  = 8
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [31:0]               req_wdata,
    output logic                      rd_valid,
    output logic [31:0]               rd_data,
    input  logic [NUM_EVT-1:0]        ev_stb,
    input  logic [NUM_EVT*PORT_W-1:0] ev_port
);
    logic             wr_ctrl;
    logic             rd_en;
    ctrl_t            wr_val;
    ctrl_t            ctrl_q;
    logic [EVT_W-1:0] echo_q;
    logic             clr_pulse;
    logic [CNT_W-1:0] sel_count;
    logic [CYC_W-1:0] cyc_q;
    logic             ctrl_freeze;
    logic [EVT_W-1:0] ctrl_evsel;
    logic             unused_wbits;

    assign wr_ctrl = req_valid && req_write && (req_addr == ADDR_W'(OFS_CTRL));
    assign rd_en   = req_valid && !req_write;

    assign wr_val.freeze = req_wdata[B_FRZ];
    assign wr_val.evsel  = req_wdata[B_EVS_LO +: EVT_W];
    assign wr_val.port   = req_wdata[B_PORT_LO +: PORT_W];
    assign wr_val.filt   = req_wdata[B_FILT];
    assign unused_wbits  = ^{req_wdata[31:24], req_wdata[22], req_wdata[15:9],
                             req_wdata[7:1]};

    assign ctrl_freeze = ctrl_q.freeze;
    assign ctrl_evsel  = ctrl_q.evsel;

    ftc_ctrl_regs u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ctrl),
        .wr_val (wr_val),
        .wr_clr (req_wdata[B_CLR]),
        .ctrl_o (ctrl_q),
        .echo_o (echo_q),
        .clr_o  (clr_pulse)
    );

    ftc_event_bank #(
        .REDUCED (REDUCED),
        .CNT_W   (CNT_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (ev_stb),
        .tags      (ev_port),
        .clr       (clr_pulse),
        .freeze    (ctrl_q.freeze),
        .filt      (ctrl_q.filt),
        .port_sel  (ctrl_q.port),
        .rd_sel    (echo_q),
        .sel_count (sel_count)
    );

    ftc_read_port #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .addr      (req_addr),
        .ctrl      (ctrl_q),
        .echo      (echo_q),
        .sel_count (sel_count),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .cyc       (cyc_q)
    );
endmodule

// File: rtl/ftc_checker.sv
module ftc_checker
    import ftc_pkg::*;
#(
    parameter bit REDUCED = 1'b0,
    parameter int CNT_W   = 60,
    parameter int ADDR_W  = 8
)(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rd_valid,
    input logic              clr,
    input logic              freeze,
    input logic [EVT_W-1:0]  evsel,
    input logic [EVT_W-1:0]  echo,
    input logic [CNT_W-1:0]  sel_count,
    input logic [CYC_W-1:0]  cyc
);
    localparam logic [NUM_EVT-1:0] SUPP = supp_mask(REDUCED);

    logic       wr_ctrl;
    logic [3:0] wsel;
    logic       unused_chk;

    assign wr_ctrl    = req_valid && req_write && (req_addr == ADDR_W'(OFS_CTRL));
    assign wsel       = req_wdata[B_EVS_LO +: EVT_W];
    assign unused_chk = ^{req_wdata[31:20], req_wdata[15:0]};

    // R2: clear leaves the visible count at zero
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> sel_count == '0);

    // R3: a steady selection grows by at most one per cycle
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && echo == evsel) |=>
            (sel_count == $past(sel_count) || sel_count == $past(sel_count) + CNT_W'(1)));

    // R5: frozen, uncleared, steady selection holds its count
    a_r5_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !clr && echo == evsel) |=> $stable(sel_count));

    // R6: echo shows the written selector two edges after the write
    a_r6_echo_follow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> ##1 (echo == $past(wsel, 2)));

    // R7: cycle counter advances every clock
    a_r7_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cyc == $past(cyc) + CYC_W'(1));

    // R8: absent events read zero in the reduced variant
    a_r8_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (REDUCED && echo < EVT_W'(NUM_EVT) && !SUPP[echo[2:0]]) |-> sel_count == '0);

    // R10: one response per read, none otherwise
    a_r10_rd_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);
    a_r10_rd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);
endmodule

bind ftc_fabric_counter ftc_checker #(
    .REDUCED (REDUCED),
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_valid  (rd_valid),
    .clr       (clr_pulse),
    .freeze    (ctrl_freeze),
    .evsel     (ctrl_evsel),
    .echo      (echo_q),
    .sel_count (sel_count),
    .cyc       (cyc_q)
);

// File: tb/ftc_fabric_counter_bench.sv
module ftc_fabric_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid, rd_valid_r;
    logic [31:0] rd_data, rd_data_r;
    logic [7:0]  ev_stb = '0;
    logic [15:0] ev_port = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ftc_fabric_counter u_ftc_fabric_counter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .ev_stb(ev_stb), .ev_port(ev_port));

    ftc_fabric_counter #(.REDUCED(1'b1)) u_ftc_fabric_counter_reduced (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid_r),
        .rd_data(rd_data_r), .ev_stb(ev_stb), .ev_port(ev_port));

    // {expected[15:12], filt[11], port[10:9], tag[8:7], event[6:4], strobes[3:0]}
    localparam logic [15:0] VEC [8] = '{
        {4'd3, 1'b0, 2'd0, 2'd3, 3'd0, 4'd3},
        {4'd4, 1'b1, 2'd1, 2'd1, 3'd1, 4'd4},
        {4'd0, 1'b1, 2'd1, 2'd2, 3'd2, 4'd5},
        {4'd2, 1'b0, 2'd2, 2'd0, 3'd3, 4'd2},
        {4'd6, 1'b1, 2'd3, 2'd3, 3'd4, 4'd6},
        {4'd0, 1'b1, 2'd0, 2'd1, 3'd5, 4'd2},
        {4'd7, 1'b0, 2'd1, 2'd2, 3'd6, 4'd7},
        {4'd1, 1'b1, 2'd2, 2'd2, 3'd7, 4'd1}
    };

    function automatic logic [31:0] cw(bit clr, bit frz, int ev, int port, bit filt);
        return 32'(clr) | (32'(frz) << 8) | (32'(ev) << 16) | (32'(port) << 20) |
               (32'(filt) << 23);
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [7:0] a, logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(logic [7:0] a, output logic [31:0] d, output logic [31:0] dr,
                          output logic v);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk); @(negedge clk);
        v = rd_valid; d = rd_data; dr = rd_data_r;
        req_valid = 1'b0;
    endtask

    task automatic pulse(logic [7:0] mask, logic [1:0] tag, int n);
        for (int i = 0; i < n; i++) begin
            ev_stb = mask; ev_port = {8{tag}};
            @(posedge clk); @(negedge clk);
            ev_stb = '0;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d, dr, c1, c2, c3;
        logic v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 idle valid", {63'd0, rd_valid}, 64'd0);
        bus_rd(8'h20, d, dr, v);
        chk("R10 valid", {63'd0, v}, 64'd1);
        chk("R10 reset ctrl", {32'd0, d}, 64'd0);
        bus_rd(8'h28, d, dr, v);
        chk("R10 reset count", {32'd0, d}, 64'd0);
        bus_rd(8'h2C, d, dr, v);
        chk("R10 reset echo", {32'd0, d}, 64'd0);

        // R3 R4 R6 table walk, neighbour event strobed alongside
        for (int k = 0; k < 8; k++) begin
            automatic logic [15:0] e = VEC[k];
            automatic int ev = int'(e[6:4]);
            automatic logic [7:0] m = (8'd1 << ev) | (8'd1 << ((ev + 1) % 8));
            bus_wr(8'h20, cw(1, 0, ev, int'(e[10:9]), e[11]));
            pulse(m, e[8:7], int'(e[3:0]));
            @(negedge clk);
            bus_rd(8'h28, d, dr, v);
            chk("R3 R4 table count", {32'd0, d}, {48'd0, 12'd0, e[15:12]});
            bus_rd(8'h2C, d, dr, v);
            chk("R6 table echo", {32'd0, d}, {32'd0, 32'(ev) << 28});
        end

        // R5 freeze
        bus_wr(8'h20, cw(1, 0, 0, 0, 0));
        pulse(8'h01, 2'd0, 2);
        bus_wr(8'h20, cw(0, 1, 0, 0, 0));
        pulse(8'h01, 2'd0, 3);
        bus_rd(8'h28, d, dr, v);
        chk("R5 frozen", {32'd0, d}, 64'd2);
        bus_wr(8'h20, cw(0, 0, 0, 0, 0));
        pulse(8'h01, 2'd0, 1);
        bus_rd(8'h28, d, dr, v);
        chk("R5 resumed", {32'd0, d}, 64'd3);

        // R4 mode change keeps counts
        bus_wr(8'h20, cw(1, 0, 1, 0, 0));
        pulse(8'h02, 2'd2, 3);
        bus_wr(8'h20, cw(0, 0, 1, 1, 1));
        bus_rd(8'h28, d, dr, v);
        chk("R4 no clear on mode change", {32'd0, d}, 64'd3);
        pulse(8'h02, 2'd1, 1);
        pulse(8'h02, 2'd2, 2);
        bus_rd(8'h28, d, dr, v);
        chk("R4 port filter", {32'd0, d}, 64'd4);

        // R2 clear wins over simultaneous strobe
        ev_stb = 8'h02; ev_port = {8{2'd1}};
        bus_wr(8'h20, cw(1, 0, 1, 1, 1));
        ev_stb = '0;
        @(negedge clk);
        bus_rd(8'h28, d, dr, v);
        chk("R2 clear priority", {32'd0, d}, 64'd0);

        // R6 echo lag
        bus_wr(8'h20, cw(0, 0, 5, 0, 0));
        bus_rd(8'h28, d, dr, v);
        bus_rd(8'h2C, d, dr, v);
        chk("R6 echo one cycle late", {32'd0, d}, {32'd0, 32'd1 << 28});
        bus_rd(8'h28, d, dr, v);
        bus_rd(8'h2C, d, dr, v);
        chk("R6 echo updated", {32'd0, d}, {32'd0, 32'd5 << 28});

        // R9 split-read capture
        bus_wr(8'h20, cw(1, 0, 0, 0, 0));
        pulse(8'h01, 2'd3, 5);
        @(negedge clk);
        bus_rd(8'h28, d, dr, v);
        chk("R9 low word", {32'd0, d}, 64'd5);
        bus_wr(8'h20, cw(0, 0, 7, 0, 0));
        repeat (2) @(negedge clk);
        bus_rd(8'h2C, d, dr, v);
        chk("R9 captured high", {32'd0, d}, 64'd0);
        bus_rd(8'h28, d, dr, v);
        bus_rd(8'h2C, d, dr, v);
        chk("R9 recaptured high", {32'd0, d}, {32'd0, 32'd7 << 28});

        // R6 out-of-range selector
        bus_wr(8'h20, cw(0, 0, 9, 0, 0));
        @(negedge clk);
        bus_rd(8'h28, d, dr, v);
        chk("R6 selector 9 count", {32'd0, d}, 64'd0);
        bus_rd(8'h2C, d, dr, v);
        chk("R6 selector 9 echo", {32'd0, d}, {32'd0, 32'd9 << 28});

        // R1 readback
        bus_wr(8'h20, 32'hFFF2_0101);
        bus_rd(8'h20, d, dr, v);
        chk("R1 ctrl readback", {32'd0, d}, 64'h00B2_0100);
        bus_rd(8'h24, d, dr, v);
        chk("R1 ctrl high", {32'd0, d}, 64'd0);
        bus_rd(8'h40, d, dr, v);
        chk("R10 unmapped", {32'd0, d}, 64'd0);

        // R7 cycle counter
        bus_rd(8'h30, c1, dr, v);
        bus_rd(8'h30, c2, dr, v);
        chk("R7 step", {32'd0, c2 - c1}, 64'd1);
        bus_wr(8'h20, cw(1, 1, 0, 0, 0));
        bus_rd(8'h30, c3, dr, v);
        chk("R7 ignores clear and freeze", {32'd0, c3 - c2}, 64'd2);
        repeat (5) @(negedge clk);
        bus_rd(8'h30, c1, dr, v);
        chk("R7 counts while frozen", {32'd0, c1 - c3}, 64'd6);
        bus_rd(8'h34, d, dr, v);
        chk("R9 cycle high", {32'd0, d}, 64'd0);

        // R8 reduced variant
        bus_wr(8'h20, cw(1, 0, 3, 0, 0));
        pulse(8'h48, 2'd2, 3);
        pulse(8'h40, 2'd1, 2);
        bus_rd(8'h28, d, dr, v);
        chk("R8 full has event 3", {32'd0, d}, 64'd3);
        chk("R8 reduced event 3 zero", {32'd0, dr}, 64'd0);
        bus_wr(8'h20, cw(0, 0, 6, 0, 0));
        @(negedge clk);
        bus_rd(8'h28, d, dr, v);
        chk("R8 reduced event 6", {32'd0, dr}, 64'd5);
        chk("R8 full event 6", {32'd0, d}, 64'd5);

        done = 1;
        finish_run();
    end
endmodule